// File: doc/BRIEF.md
# Receiver AGC Gain-State Controller with Dwell Hold

This block picks the gain state of a receiver's low-noise amplifier. A comparator flag tells it whether the received power sits above the switching threshold. When the power goes above the threshold, the block drops to low gain at once. It returns to high gain only after a programmable hold interval, and only if the power is still below the threshold when that interval ends. The hold keeps ASK symbols, whose high level is above the threshold and whose low level is below it, from switching the gain on every bit.

The hold interval is measured in ticks of a 100 kHz reference, which arrives as a one-cycle tick enable. Its length is 2^(code+4) ticks, where code is a 3-bit setting. Two overrides sit above the automatic path:
- A manual mode forces the gain from a single bit.
- A lock input keeps the amplifier in low gain once the automatic path has reached it.

The gain state is driven to the amplifier. A copy of it is provided as a status bit for readback.

Top module: `agc_gain_ctrl`

## Requirements
- R1: With manual mode off and AGC enabled, a clock edge that samples the above-threshold flag at 1 gives low gain (`gain_high` = 0) after that edge.
- R2: After the flag falls to 0 while in low gain, the gain stays low until N tick enables have been counted, where N = 2^(code+4). The edge that samples the fall counts no tick. The N-th counted tick returns the gain to high.
- R3: If the flag is 1 at any counted tick, including the N-th, the gain stays low and the hold is abandoned. A later fall of the flag starts a complete new hold of N ticks.
- R4: `dwell_code` is an unsigned binary number, with bit 2 as MSB and bit 0 as LSB. Codes 0, 3 and 7 give holds of 16, 128 and 2048 ticks.
- R5: While `manual_mode` = 1, the gain follows `manual_gain` one edge later (1 = high, 0 = low). This overrides the flag and `agc_en`.
- R6: While `lock_en` = 1, a low gain reached in automatic operation never returns to high, however many ticks pass. Locking does not stop a switch from high gain to low gain. After `lock_en` returns to 0, the gain returns to high within N further ticks.
- R7: `gain_status` reports the current gain state: 1 = high gain, 0 = low gain. It always equals `gain_high`.
- R8: During reset, and on leaving reset, the gain is high and the hold count is cleared.
- R9: With manual mode off and `agc_en` = 0, the gain is high after the next edge and any partial hold count is discarded.
- R10: On leaving manual mode with low gain and the flag at 0, a fresh hold of a full N ticks starts. Counting is not resumed from a hold that was interrupted earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_en | input | 1 | One-cycle enable at the 100 kHz reference rate |
| above_thr | input | 1 | 1 when the received power is above the switching threshold |
| dwell_code | input | 3 | Hold-length code; the hold is 2^(code+4) ticks |
| agc_en | input | 1 | 1 enables automatic gain control; 0 holds high gain |
| lock_en | input | 1 | 1 keeps low gain once it has been reached |
| manual_mode | input | 1 | 1 forces the gain from `manual_gain` |
| manual_gain | input | 1 | Forced gain in manual mode: 1 = high, 0 = low |
| gain_high | output | 1 | Gain state to the amplifier: 1 = high gain |
| gain_status | output | 1 | Readable copy of the gain state |

## Verification
The bench targets the tick count at the end of the hold. A timer that is one tick short or one tick long would return to high gain one tick early or one tick late. The bench also raises the flag on exactly the last tick. A design that decides the return before it checks the level would go to high gain at that point.

A flag that rises partway through a hold must restart the count. So must an interrupt from manual mode or from disabling the AGC. A design that kept a stale partial count would return to high gain too soon.

Under the lock, the bench lets the count run past several full intervals. A design that ignored the lock would go to high gain there. A design that never released the lock would stay in low gain after `lock_en` drops.

// File: rtl/agc_pkg.sv
package agc_pkg;

  // Decision states of the gain controller
  typedef enum logic [1:0] {
    GS_HIGH      = 2'd0,  // high gain, level below threshold
    GS_LOW_HOLD  = 2'd1,  // low gain, level above threshold
    GS_LOW_DWELL = 2'd2   // low gain, level below, counting hold ticks
  } gain_state_e;

endpackage

// File: rtl/agc_rst_sync.sv
module agc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  // Shift a one into the synchronizer chain.
  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/agc_dwell_timer.sv
module agc_dwell_timer #(
  parameter int CODE_W   = 3,
  parameter int BASE_EXP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic [CODE_W-1:0] dwell_code_i,
  output logic              done_o
);

  // The widest hold is 2^(BASE_EXP + 2^CODE_W - 1) ticks.
  localparam int MAX_EXP = BASE_EXP + (1 << CODE_W) - 1;
  localparam int CNT_W   = MAX_EXP;
  localparam int SH_W    = $clog2(MAX_EXP + 1);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic [CNT_W-1:0] last_val;
  logic [SH_W-1:0]  shamt;
  logic             at_last;

  always_comb begin
    shamt = SH_W'(dwell_code_i) + SH_W'(BASE_EXP);
    // At the widest code the shift wraps to zero, and zero minus one is all ones.
    last_val = ({{(CNT_W-1){1'b0}}, 1'b1} << shamt) - {{(CNT_W-1){1'b0}}, 1'b1};
    at_last  = (count_q == last_val);
    done_o   = step_i && at_last;
  end

  always_comb begin
    count_d = count_q;
    if (clear_i) begin
      count_d = '0;
    end else if (step_i) begin
      if (at_last) count_d = '0;
      else         count_d = count_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

endmodule

// File: rtl/agc_gain_fsm.sv
module agc_gain_fsm
  import agc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic above_i,
  input  logic agc_en_i,
  input  logic lock_en_i,
  input  logic manual_i,
  input  logic manual_gain_i,
  input  logic tick_i,
  input  logic dwell_done_i,
  output logic gain_high_o,
  output logic timer_clear_o,
  output logic timer_step_o
);

  gain_state_e state_q;
  gain_state_e state_d;

  always_comb begin
    state_d       = state_q;
    timer_clear_o = 1'b0;
    timer_step_o  = 1'b0;
    if (manual_i) begin
      // Manual override: the state mirrors the forced gain and the hold restarts.
      state_d       = manual_gain_i ? GS_HIGH : GS_LOW_HOLD;
      timer_clear_o = 1'b1;
    end else if (!agc_en_i) begin
      state_d       = GS_HIGH;
      timer_clear_o = 1'b1;
    end else begin
      unique case (state_q)
        GS_HIGH: begin
          timer_clear_o = 1'b1;
          if (above_i) state_d = GS_LOW_HOLD;
        end
        GS_LOW_HOLD: begin
          timer_clear_o = 1'b1;
          if (!above_i) state_d = GS_LOW_DWELL;
        end
        GS_LOW_DWELL: begin
          if (above_i) begin
            state_d       = GS_LOW_HOLD;
            timer_clear_o = 1'b1;
          end else begin
            timer_step_o = tick_i;
            if (dwell_done_i && !lock_en_i) state_d = GS_HIGH;
          end
        end
        default: begin
          state_d       = GS_HIGH;
          timer_clear_o = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= GS_HIGH;
    else        state_q <= state_d;
  end

  assign gain_high_o = (state_q == GS_HIGH);

endmodule

// File: rtl/agc_gain_ctrl.sv
module agc_gain_ctrl #(
  parameter int CODE_W      = 3,
  parameter int BASE_EXP    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              above_thr,
  input  logic [CODE_W-1:0] dwell_code,
  input  logic              agc_en,
  input  logic              lock_en,
  input  logic              manual_mode,
  input  logic              manual_gain,
  output logic              gain_high,
  output logic              gain_status
);

  logic rst_sync_n;
  logic tmr_clear;
  logic tmr_step;
  logic tmr_done;
  logic gain_q;

  agc_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  agc_dwell_timer #(.CODE_W(CODE_W), .BASE_EXP(BASE_EXP)) i_timer (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .clear_i      (tmr_clear),
    .step_i       (tmr_step),
    .dwell_code_i (dwell_code),
    .done_o       (tmr_done)
  );

  agc_gain_fsm i_fsm (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .above_i       (above_thr),
    .agc_en_i      (agc_en),
    .lock_en_i     (lock_en),
    .manual_i      (manual_mode),
    .manual_gain_i (manual_gain),
    .tick_i        (tick_en),
    .dwell_done_i  (tmr_done),
    .gain_high_o   (gain_q),
    .timer_clear_o (tmr_clear),
    .timer_step_o  (tmr_step)
  );

  assign gain_high   = gain_q;
  assign gain_status = gain_q;

endmodule

// File: rtl/agc_gain_ctrl_chk.sv
module agc_gain_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic above_thr,
  input logic agc_en,
  input logic lock_en,
  input logic manual_mode,
  input logic manual_gain,
  input logic tick_en,
  input logic gain_high
);

  // R1: a sampled level above the threshold in automatic operation gives low gain.
  p_low_on_above_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!manual_mode && agc_en && above_thr) |=> !gain_high);

  // R2: low gain returns to high only on an edge that counts a tick.
  p_no_return_without_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!manual_mode && agc_en && !gain_high && !tick_en) |=> !gain_high);

  // R5: manual mode forces the gain.
  p_manual_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    manual_mode |=> (gain_high == $past(manual_gain)));

  // R6: the lock keeps low gain in place.
  p_lock_holds_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!manual_mode && agc_en && lock_en && !gain_high) |=> !gain_high);

  // R9: with AGC disabled the gain is high.
  p_disabled_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!manual_mode && !agc_en) |=> gain_high);

endmodule

bind agc_gain_ctrl agc_gain_ctrl_chk i_agc_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .above_thr   (above_thr),
  .agc_en      (agc_en),
  .lock_en     (lock_en),
  .manual_mode (manual_mode),
  .manual_gain (manual_gain),
  .tick_en     (tick_en),
  .gain_high   (gain_high)
);

// File: tb/test_agc_gain_ctrl.sv
module test_agc_gain_ctrl;

  logic       clk;
  logic       rst_n;
  logic       tick_en;
  logic       above_thr;
  logic [2:0] dwell_code;
  logic       agc_en;
  logic       lock_en;
  logic       manual_mode;
  logic       manual_gain;
  logic       gain_high;
  logic       gain_status;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  agc_gain_ctrl i_agc_gain_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .above_thr   (above_thr),
    .dwell_code  (dwell_code),
    .agc_en      (agc_en),
    .lock_en     (lock_en),
    .manual_mode (manual_mode),
    .manual_gain (manual_gain),
    .gain_high   (gain_high),
    .gain_status (gain_status)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // R7: the status copy is checked at every gain check.
  task automatic chk_gain(input logic exp, input string req, input string what);
    chk(gain_high, exp, req, what);
    chk(gain_status, exp, "R7", what);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_en = 1'b1;
      @(negedge clk) tick_en = 1'b0;
    end
  endtask

  // Enter low gain and start a hold (the level falls back below the threshold).
  task automatic go_low_and_fall();
    @(negedge clk);
    above_thr = 1'b1;
    @(negedge clk);
    above_thr = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; above_thr = 1'b1; agc_en = 1'b1;
    repeat (3) @(negedge clk);
    chk_gain(1'b1, "R8", "gain during reset");
    rst_n = 1'b1; above_thr = 1'b0;
    repeat (3) @(negedge clk);
    chk_gain(1'b1, "R8", "gain after reset");
  endtask

  task automatic t_attack();
    above_thr = 1'b1;
    @(negedge clk);
    chk_gain(1'b0, "R1", "low gain one edge after rise");
    above_thr = 1'b0;
    @(negedge clk);
    chk_gain(1'b0, "R2", "still low right after fall");
    ticks(16);
  endtask

  task automatic t_dwell(input logic [2:0] code);
    int n;
    n = 1 << (code + 4);
    dwell_code = code;
    go_low_and_fall();
    ticks(n - 1);
    chk_gain(1'b0, "R2", $sformatf("low after N-1 ticks, code %0d", code));
    ticks(1);
    chk_gain(1'b1, "R4", $sformatf("high after N ticks, code %0d", code));
  endtask

  task automatic t_rise_at_end();
    dwell_code = 3'd0;
    go_low_and_fall();
    ticks(15);
    @(negedge clk); above_thr = 1'b1; tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
    chk_gain(1'b0, "R3", "rise on last tick keeps low");
    above_thr = 1'b0;
    @(negedge clk);
    ticks(15);
    chk_gain(1'b0, "R3", "new hold is a full one after end rise");
    ticks(1);
    chk_gain(1'b1, "R3", "high after new full hold");
  endtask

  task automatic t_rise_mid();
    dwell_code = 3'd0;
    go_low_and_fall();
    ticks(10);
    above_thr = 1'b1;
    @(negedge clk);
    above_thr = 1'b0;
    @(negedge clk);
    ticks(15);
    chk_gain(1'b0, "R3", "mid-hold rise restarts count");
    ticks(1);
    chk_gain(1'b1, "R3", "high after restarted hold");
  endtask

  task automatic t_manual();
    manual_mode = 1'b1; manual_gain = 1'b0;
    @(negedge clk);
    chk_gain(1'b0, "R5", "manual low");
    manual_gain = 1'b1; above_thr = 1'b1;
    @(negedge clk);
    chk_gain(1'b1, "R5", "manual high with level above");
    agc_en = 1'b0; manual_gain = 1'b0;
    @(negedge clk);
    chk_gain(1'b0, "R5", "manual low with AGC disabled");
    agc_en = 1'b1; manual_gain = 1'b1; above_thr = 1'b0;
    @(negedge clk);
    manual_mode = 1'b0;
    @(negedge clk);
    chk_gain(1'b1, "R10", "leaving manual high stays high");
  endtask

  task automatic t_lock();
    int k;
    dwell_code = 3'd0;
    lock_en = 1'b1;
    go_low_and_fall();
    chk_gain(1'b0, "R6", "lock does not prevent switch to low");
    ticks(40);
    chk_gain(1'b0, "R6", "locked low after 40 ticks");
    lock_en = 1'b0;
    k = 0;
    while (gain_high !== 1'b1 && k < 16) begin
      ticks(1);
      k++;
    end
    chk_gain(1'b1, "R6", "released within one hold");
  endtask

  task automatic t_disable();
    dwell_code = 3'd0;
    go_low_and_fall();
    ticks(8);
    agc_en = 1'b0;
    @(negedge clk);
    chk_gain(1'b1, "R9", "disable gives high gain");
    above_thr = 1'b1;
    @(negedge clk);
    chk_gain(1'b1, "R9", "disabled ignores level above");
    above_thr = 1'b0; agc_en = 1'b1;
    go_low_and_fall();
    ticks(15);
    chk_gain(1'b0, "R9", "partial count discarded");
    ticks(1);
    chk_gain(1'b1, "R9", "full hold after re-enable");
  endtask

  task automatic t_resume();
    dwell_code = 3'd0;
    go_low_and_fall();
    ticks(10);
    manual_mode = 1'b1; manual_gain = 1'b0;
    repeat (2) @(negedge clk);
    manual_mode = 1'b0;
    @(negedge clk);
    ticks(15);
    chk_gain(1'b0, "R10", "fresh hold after manual exit");
    ticks(1);
    chk_gain(1'b1, "R10", "high after fresh hold");
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; above_thr = 1'b0; dwell_code = 3'd0;
    agc_en = 1'b1; lock_en = 1'b0; manual_mode = 1'b0; manual_gain = 1'b0;
    t_reset();
    t_attack();
    t_dwell(3'd0);
    t_dwell(3'd3);
    t_dwell(3'd7);
    t_rise_at_end();
    t_rise_mid();
    t_manual();
    t_lock();
    t_disable();
    t_resume();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule